// File: doc/BRIEF.md
# Round-Robin Two-Phase Batch Scheduler

This block takes one parallel step of `y` independent operations and hands it out to a fixed set of worker lanes. The lanes take the operations in a fixed round-robin pattern. Each cycle of an active step it presents one round. A round is a mask of valid lanes, plus the 1-based operation index that each lane carries. Consecutive lanes take consecutive indices, and each round moves on by the lane count.

Every step is issued twice, as two phases:

- The read phase comes first and issues every index once.
- The write phase follows directly and issues every index once more.

So no write of a step can reach the workers before the last read of that step. The block pulses a marker when each phase ends and a marker when the whole step ends. It does not model the workers, the memory or what the operations do. It only sequences indices and phases. The count is captured when the step starts, and a start that arrives during a step is dropped.

Top module: `rrs_sched`

## Requirements
- R1: After reset, `lane_vld`, `lane_idx`, `wr_phase`, `rd_done`, `wr_done`, `step_done` and `busy` are all zero.
- R2: When `start` is high on a clock edge while `busy` is low and `op_count` is nonzero, the block captures `op_count` and raises `busy` after that edge. The first read round appears one edge later.
- R3: In round r (from 1) of a phase, lane j (from 0, bit j of `lane_vld`, bits `[j*CNT_W +: CNT_W]` of `lane_idx`) carries index j+1+(r-1)*LANES. Its valid bit is set exactly when that index is not above the captured count.
- R4: A lane whose valid bit is clear shows index 0. Every round of a phase except its last has all lanes valid.
- R5: The read phase lasts ceil(y/LANES) consecutive rounds with `wr_phase` low. The write phase of the same length follows at once with `wr_phase` high. No write round comes before the last read round.
- R6: `rd_done` is high only together with the last read round. `wr_done` and `step_done` are high only together with the last write round, and `busy` is low in that same cycle.
- R7: A start with `op_count` of zero produces one cycle, one edge later, in which `rd_done`, `wr_done` and `step_done` are all high and no lane is valid. `busy` stays low.
- R8: `start` is ignored while `busy` is high. The running schedule and its count are unchanged.
- R9: Within each phase, every index from 1 to y appears on a valid lane exactly once, and no other index appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a step (taken only when idle) |
| op_count | input | CNT_W | Number of operations y in the step |
| lane_vld | output | LANES | Valid mask of the current round, bit j for lane j |
| lane_idx | output | LANES*CNT_W | Per-lane 1-based operation index, lane j in bits [j*CNT_W +: CNT_W] |
| wr_phase | output | 1 | Current round belongs to the write phase |
| rd_done | output | 1 | Pulses with the last read round |
| wr_done | output | 1 | Pulses with the last write round |
| step_done | output | 1 | Pulses when the whole step has been issued |
| busy | output | 1 | A step is in progress |

## Verification
Every count from 0 to 40 is run on four lanes, together with the largest count. This covers exact multiples of the lane count, where the last round is full, and each remainder from one to three, where the tail is partly idle. Small counts separate the one-round-per-phase case from longer phases. A count of zero exercises the empty-step path. Some runs raise `start` in the middle of a step with a different count, to show that a late start cannot restart the sequence or change its length. For every run, the bench tallies each index per phase and compares every round with the computed mask and index values.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } rrs_st_e;
endpackage

// File: rtl/rrs_lane_gen.sv
module rrs_lane_gen #(
    parameter int LANES = 4,
    parameter int CNT_W = 8,
    parameter int BW    = CNT_W + 4
) (
    input  logic [BW-1:0]          base,
    input  logic [CNT_W-1:0]       total,
    output logic [LANES-1:0]       vld,
    output logic [LANES*CNT_W-1:0] idx
);
    localparam int PADW = BW - CNT_W;

    logic [BW-1:0] total_ext;
    assign total_ext = {{PADW{1'b0}}, total};

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [BW-1:0] cand;
        assign cand   = base + BW'(j + 1);
        assign vld[j] = (cand <= total_ext);
        assign idx[j*CNT_W +: CNT_W] = vld[j] ? cand[CNT_W-1:0] : '0;
    end
endmodule

// File: rtl/rrs_phase_fsm.sv
module rrs_phase_fsm (
    input  rrs_pkg::rrs_st_e st_q,
    input  logic             start,
    input  logic             count_zero,
    input  logic             last_round,
    output rrs_pkg::rrs_st_e st_d,
    output logic             load,
    output logic             zero_done,
    output logic             adv,
    output logic             rd_last,
    output logic             wr_last
);
    import rrs_pkg::*;

    always_comb begin
        st_d      = st_q;
        load      = 1'b0;
        zero_done = 1'b0;
        adv       = 1'b0;
        rd_last   = 1'b0;
        wr_last   = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (start) begin
                    if (count_zero) begin
                        zero_done = 1'b1;
                    end else begin
                        load = 1'b1;
                        st_d = ST_RD;
                    end
                end
            end
            ST_RD: begin
                adv = 1'b1;
                if (last_round) begin
                    rd_last = 1'b1;
                    st_d    = ST_WR;
                end
            end
            ST_WR: begin
                adv = 1'b1;
                if (last_round) begin
                    wr_last = 1'b1;
                    st_d    = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/rrs_sched.sv
module rrs_sched #(
    parameter int LANES = 4,
    parameter int CNT_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [CNT_W-1:0]       op_count,
    output logic [LANES-1:0]       lane_vld,
    output logic [LANES*CNT_W-1:0] lane_idx,
    output logic                   wr_phase,
    output logic                   rd_done,
    output logic                   wr_done,
    output logic                   step_done,
    output logic                   busy
);
    import rrs_pkg::*;

    localparam int BW = CNT_W + $clog2(LANES + 1) + 1;

    typedef struct packed {
        rrs_st_e                st;
        logic [BW-1:0]          base;
        logic [CNT_W-1:0]       total;
        logic [LANES-1:0]       vld;
        logic [LANES*CNT_W-1:0] idx;
        logic                   wr;
        logic                   rd_done;
        logic                   wr_done;
        logic                   step_done;
    } regs_t;

    regs_t r_d, r_q;

    logic [LANES-1:0]       gen_vld;
    logic [LANES*CNT_W-1:0] gen_idx;
    logic                   last_round;
    rrs_st_e                st_nxt;
    logic                   load, zero_done, adv, rd_last, wr_last;

    assign last_round = (r_q.base + BW'(LANES)) >= {{(BW-CNT_W){1'b0}}, r_q.total};

    rrs_lane_gen #(.LANES(LANES), .CNT_W(CNT_W), .BW(BW)) i_lane_gen (
        .base  (r_q.base),
        .total (r_q.total),
        .vld   (gen_vld),
        .idx   (gen_idx)
    );

    rrs_phase_fsm i_phase_fsm (
        .st_q       (r_q.st),
        .start      (start),
        .count_zero (op_count == '0),
        .last_round (last_round),
        .st_d       (st_nxt),
        .load       (load),
        .zero_done  (zero_done),
        .adv        (adv),
        .rd_last    (rd_last),
        .wr_last    (wr_last)
    );

    always_comb begin
        r_d           = r_q;
        r_d.st        = st_nxt;
        r_d.vld       = '0;
        r_d.idx       = '0;
        r_d.wr        = 1'b0;
        r_d.rd_done   = 1'b0;
        r_d.wr_done   = 1'b0;
        r_d.step_done = 1'b0;
        if (load) begin
            r_d.total = op_count;
            r_d.base  = '0;
        end
        if (zero_done) begin
            r_d.rd_done   = 1'b1;
            r_d.wr_done   = 1'b1;
            r_d.step_done = 1'b1;
        end
        if (adv) begin
            r_d.vld  = gen_vld;
            r_d.idx  = gen_idx;
            r_d.wr   = (r_q.st == ST_WR);
            r_d.base = r_q.base + BW'(LANES);
            if (rd_last) begin
                r_d.base    = '0;
                r_d.rd_done = 1'b1;
            end
            if (wr_last) begin
                r_d.wr_done   = 1'b1;
                r_d.step_done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign lane_vld  = r_q.vld;
    assign lane_idx  = r_q.idx;
    assign wr_phase  = r_q.wr;
    assign rd_done   = r_q.rd_done;
    assign wr_done   = r_q.wr_done;
    assign step_done = r_q.step_done;
    assign busy      = (r_q.st != ST_IDLE);

    // R4
    full_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|r_q.vld) && !r_q.rd_done && !r_q.wr_done) |-> (&r_q.vld));

    // R4
    for (genvar j = 0; j < LANES; j++) begin : g_idle_chk
        idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !r_q.vld[j] |-> (r_q.idx[j*CNT_W +: CNT_W] == '0));
    end

    // R5
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.wr) |-> $past(r_q.rd_done));

    // R3
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st != ST_IDLE) && !last_round) |=> (r_q.base == $past(r_q.base) + BW'(LANES)));

    // R7
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st == ST_IDLE) && start && (op_count == '0)) |=> (r_q.step_done && (r_q.vld == '0)));

    // R8
    hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.st != ST_IDLE) && $past(r_q.st != ST_IDLE)) |-> $stable(r_q.total));

    // R6
    done_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.step_done |-> (r_q.wr_done && r_q.rd_done == (r_q.vld == '0) && !busy));
endmodule

// File: tb/test_rrs_sched.sv
module test_rrs_sched;
    localparam int LANES = 4;
    localparam int CNT_W = 8;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [CNT_W-1:0]       op_count = '0;
    logic [LANES-1:0]       lane_vld;
    logic [LANES*CNT_W-1:0] lane_idx;
    logic                   wr_phase, rd_done, wr_done, step_done, busy;

    int n_chk = 0;
    int n_bad = 0;
    int seen_rd [256];
    int seen_wr [256];

    always #2 clk = ~clk;

    rrs_sched #(.LANES(LANES), .CNT_W(CNT_W)) i_rrs_sched (
        .clk(clk), .rst_n(rst_n), .start(start), .op_count(op_count),
        .lane_vld(lane_vld), .lane_idx(lane_idx), .wr_phase(wr_phase),
        .rd_done(rd_done), .wr_done(wr_done), .step_done(step_done), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_step(input int y, input bit poke);
        int rounds;
        int last_c;
        rounds = (y + LANES - 1) / LANES;
        last_c = (y == 0) ? 1 : 2 * rounds + 1;
        for (int i = 0; i < 256; i++) begin
            seen_rd[i] = 0;
            seen_wr[i] = 0;
        end
        @(negedge clk);
        start    = 1'b1;
        op_count = CNT_W'(y);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c <= last_c; c++) begin
            logic [LANES-1:0]       e_vld;
            logic [LANES*CNT_W-1:0] e_idx;
            bit e_wr, e_rd, e_wd, e_busy;
            e_vld = '0;
            e_idx = '0;
            e_wr  = 0;
            e_rd  = 0;
            e_wd  = 0;
            e_busy = 0;
            if (y == 0) begin
                e_rd = (c == 0);
                e_wd = (c == 0);
            end else begin
                e_busy = (c < 2 * rounds);
                if (c >= 1 && c <= 2 * rounds) begin
                    int r;
                    r = (c > rounds) ? c - rounds : c;
                    e_wr = (c > rounds);
                    e_rd = (c == rounds);
                    e_wd = (c == 2 * rounds);
                    for (int j = 0; j < LANES; j++) begin
                        int ix;
                        ix = j + 1 + (r - 1) * LANES;
                        if (ix <= y) begin
                            e_vld[j] = 1'b1;
                            e_idx[j*CNT_W +: CNT_W] = CNT_W'(ix);
                        end
                    end
                end
            end
            // R3 R4 mask and per-lane indices
            chk(lane_vld == e_vld, "R3 lane_vld", lane_vld, e_vld);
            chk(lane_idx == e_idx, "R4 lane_idx", lane_idx, e_idx);
            // R5 phase tag
            chk(wr_phase == e_wr, "R5 wr_phase", wr_phase, e_wr);
            // R6 R7 done pulses
            chk(rd_done == e_rd, (y == 0) ? "R7 rd_done" : "R6 rd_done", rd_done, e_rd);
            chk({wr_done, step_done} == {e_wd, e_wd}, (y == 0) ? "R7 wr/step_done" : "R6 wr/step_done",
                {wr_done, step_done}, {e_wd, e_wd});
            // R2 R8 busy
            chk(busy == e_busy, poke ? "R8 busy" : "R2 busy", busy, e_busy);
            for (int j = 0; j < LANES; j++) begin
                if (lane_vld[j]) begin
                    if (wr_phase) seen_wr[lane_idx[j*CNT_W +: CNT_W]]++;
                    else          seen_rd[lane_idx[j*CNT_W +: CNT_W]]++;
                end
            end
            if (poke && c == 1) begin
                start    = 1'b1;
                op_count = CNT_W'(y ^ 5);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        begin
            bit cov_ok;
            int bad_i;
            cov_ok = 1;
            bad_i  = 0;
            for (int i = 0; i < 256; i++) begin
                int want;
                want = (i >= 1 && i <= y) ? 1 : 0;
                if (seen_rd[i] != want || seen_wr[i] != want) begin
                    if (cov_ok) bad_i = i;
                    cov_ok = 0;
                end
            end
            // R9 each index once per phase
            chk(cov_ok, "R9 coverage", {seen_rd[bad_i], seen_wr[bad_i]}, (bad_i >= 1 && bad_i <= y) ? 64'h1_0000_0001 : 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({lane_vld, lane_idx, wr_phase, rd_done, wr_done, step_done, busy} == '0,
            "R1 reset", {lane_vld, wr_phase, rd_done, wr_done, step_done, busy}, 0);
        rst_n = 1'b1;
        for (int y = 0; y <= 40; y++) run_step(y, 1'b0);
        run_step(255, 1'b0);
        run_step(1, 1'b1);
        run_step(7, 1'b1);
        run_step(16, 1'b1);
        run_step(0, 1'b1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule